// File: doc/BRIEF.md
# Cascadable Duty-Code Serial Slave

This block is the host-facing serial port of a four-channel PWM load driver. A host selects the device by pulling the active-low select line low. It then clocks a 16-bit frame in, most significant bit first. The frame holds four 4-bit duty codes, one for each output channel. In the same transfer the device shifts out a 16-bit diagnostic word, which the surrounding logic supplies on `diag_word`. All serial inputs are sampled into the system clock domain through a synchronizer of configurable depth. Every edge decision is made on the synchronized levels.

The received word is written to the duty registers when select is released, and only if the number of serial clocks in the transfer was a nonzero multiple of the frame length. Any other count leaves the previous settings in place. The shift register is exactly one frame long, so bits clocked in beyond the first frame come out again on the data output one frame later. Several devices can therefore be chained data-out to data-in, and each keeps the last frame it received. A synchronous reset clears every duty code to zero, which turns all outputs off.

Top module: `duty_link_slave`

## Requirements
- R1: While `cs_n` is high, `sdo_en` is 0 and `sdo` is 0. While `cs_n` is low, `sdo_en` is 1.
- R2: The diagnostic word is captured when select goes low. Each rising `sclk` edge places the next bit of that word on `sdo`, starting with bit 15.
- R3: `sdi` is sampled on each falling `sclk` edge, and the first bit sampled becomes bit 15 of the received word.
- R4: In a committed word, bits 3:0 are the channel 1 duty code (bit 0 is its LSB), bits 7:4 are channel 2, bits 11:8 are channel 3 and bits 15:12 are channel 4. Channel k appears on `duty_o[4k-1:4k-4]`.
- R5: The received word is committed when `cs_n` rises, and only if the count of falling `sclk` edges is 16·n with n ≥ 1. Otherwise `duty_o` keeps its value. `duty_o` never changes while `sdo_en` is 1.
- R6: In a frame longer than 16 clocks, the bit on `sdo` after rising edge 16+k equals the `sdi` bit sampled on falling edge k. The committed word is made of the last 16 bits received.
- R7: `sclk` and `sdi` activity while `cs_n` is high changes neither `duty_o` nor the next frame.
- R8: Synchronous reset sets every duty code to 0000 and `sdo_en` to 0.
- R9: The clock count restarts at every falling `cs_n`. An aborted short frame does not affect whether the next frame is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| diag_word | input | 16 | Diagnostic word returned in the next frame |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable of the tri-state `sdo` pad |
| duty_o | output | 16 | Four committed 4-bit duty codes |

## Verification
Each pin change takes two synchronizer cycles and one edge-detect cycle before it acts. A falling `cs_n` raises `sdo_en` on the third clock. A rising `sclk` updates `sdo` on the third clock. A rising `cs_n` updates `duty_o` and drops `sdo_en` on the third clock. The bench holds every serial phase for four system clocks and samples `sdo` at the end of the high phase. It checks `duty_o` and `sdo_en` six clocks after `cs_n` rises. This way every result is read after it is due and before the next stimulus can change it. Expected outputs are computed from frame length, transmitted bits and diagnostic word alone.

// File: rtl/duty_link_pkg.sv
package duty_link_pkg;
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } edge_info_t;
endpackage

// File: rtl/duty_link_sync.sv
module duty_link_sync #(
   parameter int       STAGES  = 2,
   parameter int       W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic [W-1:0]                        pin_i,
   output duty_link_pkg::edge_info_t [W-1:0]   edge_o
);
   logic [W-1:0] lvl;
   logic [W-1:0] prev_q;

   if (STAGES < 0 || STAGES > 8) begin : g_bad_stages
      $error("duty_link_sync: STAGES must lie in 0..8");
   end

   if (STAGES == 0) begin : g_bypass
      assign lvl = pin_i;
   end else begin : g_chain
      logic [W-1:0] chain_q [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
         end else begin
            chain_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         end
      end
      assign lvl = chain_q[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= RST_VAL;
      else     prev_q <= lvl;
   end

   for (genvar b = 0; b < W; b++) begin : g_edge
      assign edge_o[b].level = lvl[b];
      assign edge_o[b].rise  = lvl[b] & ~prev_q[b];
      assign edge_o[b].fall  = ~lvl[b] & prev_q[b];
   end
endmodule

// File: rtl/duty_link_shifter.sv
module duty_link_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] status_i,
   input  logic               shift_i,
   input  logic               emit_i,
   input  logic               clear_i,
   input  logic               sdi_i,
   output logic [FRAME_W-1:0] word_o,
   output logic               sdo_o
);
   logic [FRAME_W-1:0] shreg_q;
   logic               out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q <= '0;
      end else if (load_i) begin
         shreg_q <= status_i;
      end else if (shift_i) begin
         shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
      end
   end

   always_ff @(posedge clk) begin
      if (rst || load_i || clear_i) out_q <= 1'b0;
      else if (emit_i)              out_q <= shreg_q[FRAME_W-1];
   end

   assign word_o = shreg_q;
   assign sdo_o  = out_q;
endmodule

// File: rtl/duty_link_framecnt.sv
module duty_link_framecnt #(
   parameter int FRAME_W = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic tick_i,
   output logic valid_o
);
   localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             full_q;

   always_ff @(posedge clk) begin
      if (rst || start_i) begin
         cnt_q  <= '0;
         full_q <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            full_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign valid_o = full_q && (cnt_q == '0);
endmodule

// File: rtl/duty_link_slave.sv
module duty_link_slave #(
   parameter int CHANNELS    = 4,
   parameter int DUTY_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W    = CHANNELS * DUTY_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               sdi,
   input  logic [FRAME_W-1:0] diag_word,
   output logic               sdo,
   output logic               sdo_en,
   output logic [FRAME_W-1:0] duty_o
);
   localparam int IDX_CS   = 2;
   localparam int IDX_SCLK = 1;
   localparam int IDX_SDI  = 0;

   if (CHANNELS < 1 || DUTY_W < 1 || FRAME_W < 2) begin : g_bad_shape
      $error("duty_link_slave: frame must hold at least two bits");
   end

   duty_link_pkg::edge_info_t [2:0] pins;
   logic               active_q;
   logic               sel_on, sel_off, clk_rise, clk_fall;
   logic               frame_ok;
   logic [FRAME_W-1:0] rx_word;

   duty_link_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (3),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk    (clk),
      .rst    (rst),
      .pin_i  ({cs_n, sclk, sdi}),
      .edge_o (pins)
   );

   assign sel_on   = pins[IDX_CS].fall;
   assign sel_off  = pins[IDX_CS].rise & active_q;
   assign clk_rise = pins[IDX_SCLK].rise & active_q & ~pins[IDX_CS].level;
   assign clk_fall = pins[IDX_SCLK].fall & active_q & ~pins[IDX_CS].level;

   always_ff @(posedge clk) begin
      if (rst)          active_q <= 1'b0;
      else if (sel_on)  active_q <= 1'b1;
      else if (sel_off) active_q <= 1'b0;
   end

   duty_link_shifter #(.FRAME_W(FRAME_W)) i_shift (
      .clk      (clk),
      .rst      (rst),
      .load_i   (sel_on),
      .status_i (diag_word),
      .shift_i  (clk_fall),
      .emit_i   (clk_rise),
      .clear_i  (sel_off),
      .sdi_i    (pins[IDX_SDI].level),
      .word_o   (rx_word),
      .sdo_o    (sdo)
   );

   duty_link_framecnt #(.FRAME_W(FRAME_W)) i_cnt (
      .clk     (clk),
      .rst     (rst),
      .start_i (sel_on),
      .tick_i  (clk_fall),
      .valid_o (frame_ok)
   );

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      logic [DUTY_W-1:0] code_q;
      always_ff @(posedge clk) begin
         if (rst)                       code_q <= '0;
         else if (sel_off && frame_ok)  code_q <= rx_word[c*DUTY_W +: DUTY_W];
      end
      assign duty_o[c*DUTY_W +: DUTY_W] = code_q;
   end

   assign sdo_en = active_q;
endmodule

// File: rtl/duty_link_checker.sv
module duty_link_checker #(
   parameter int FRAME_W = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               sdo,
   input logic               sdo_en,
   input logic [FRAME_W-1:0] duty_o
);
   AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
      !sdo_en |-> !sdo);                                   // R1
   AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
      !$isunknown({sdo, sdo_en}));                         // R2
   AST_DUTY_FROZEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      sdo_en |-> $stable(duty_o));                         // R5
   AST_DUTY_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !$past(sdo_en) |-> $stable(duty_o));                 // R5
   AST_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (duty_o == '0 && !sdo_en));           // R8
endmodule

bind duty_link_slave duty_link_checker #(.FRAME_W(FRAME_W)) i_chk (
   .clk    (clk),
   .rst    (rst),
   .sdo    (sdo),
   .sdo_en (sdo_en),
   .duty_o (duty_o)
);

// File: tb/test_duty_link_slave.sv
module test_duty_link_slave;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic [15:0] diag_word = '0;
   logic        sdo, sdo_en;
   logic [15:0] duty_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   duty_link_slave i_duty_link_slave (
      .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
      .diag_word (diag_word), .sdo (sdo), .sdo_en (sdo_en), .duty_o (duty_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_stream(input int n, input logic [63:0] tx, input logic [15:0] st);
      logic [63:0] e = '0;
      for (int i = 0; i < n; i++)
         e[i] = (i < 16) ? st[15-i] : tx[n-1-(i-16)];
      return e;
   endfunction

   function automatic logic [15:0] exp_duty(input int n, input logic [63:0] tx, input logic [15:0] prev);
      return (n > 0 && n % 16 == 0) ? tx[15:0] : prev;
   endfunction

   task automatic idle_wiggle(input int n);
      for (int i = 0; i < n; i++) begin
         sdi = i[0]; sclk = 1'b1; repeat (4) @(negedge clk);
         sclk = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   task automatic frame(input int n, input logic [63:0] tx, input logic [15:0] st);
      logic [63:0] rx = '0;
      logic [63:0] e, m16, mhi;
      logic [15:0] prev = duty_o;
      diag_word = st;
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk(sdo_en == 1'b1, "R1 enable while selected", 64'(sdo_en), 64'd1);
      for (int i = 0; i < n; i++) begin
         sdi = tx[n-1-i]; sclk = 1'b1; repeat (4) @(negedge clk);
         rx[i] = sdo;
         sclk = 1'b0; repeat (4) @(negedge clk);
      end
      chk(duty_o == prev, "R5 no change while selected", 64'(duty_o), 64'(prev));
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      e   = exp_stream(n, tx, st);
      m16 = (n >= 16) ? 64'hFFFF : ((64'd1 << n) - 1);
      mhi = (n >= 64) ? ~64'd0 : ((64'd1 << n) - 1);
      mhi = mhi & ~m16;
      chk((rx & m16) == (e & m16), "R2 status bits MSB first", rx & m16, e & m16);
      if (n > 16)
         chk((rx & mhi) == (e & mhi), "R6 pass-through delay", rx & mhi, e & mhi);
      chk(duty_o == exp_duty(n, tx, prev), "R3/R5 commit rule", 64'(duty_o), 64'(exp_duty(n, tx, prev)));
      chk(sdo_en == 1'b0 && sdo == 1'b0, "R1 released", {sdo_en, sdo}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      // R8 reset state
      chk(duty_o == 16'h0 && sdo_en == 1'b0, "R8 reset state", {duty_o, sdo_en}, 64'd0);

      // R4 channel mapping, R3 first bit lands at bit 15
      frame(16, 64'h4321, 16'hA5C3);
      chk(duty_o[3:0] == 4'h1 && duty_o[7:4] == 4'h2 && duty_o[11:8] == 4'h3 && duty_o[15:12] == 4'h4,
          "R4 channel nibbles", 64'(duty_o), 64'h4321);

      // R6 cascade: 32 clocks, last 16 bits commit
      frame(32, 64'hBEEF_1357, 16'h8001);
      chk(duty_o == 16'h1357, "R6 last word kept", 64'(duty_o), 64'h1357);

      // R5 invalid length keeps settings
      frame(17, 64'h1FFFF, 16'hFFFF);
      chk(duty_o == 16'h1357, "R5 odd length ignored", 64'(duty_o), 64'h1357);

      // R7 activity while deselected
      held = duty_o;
      idle_wiggle(16);
      chk(duty_o == held && sdo_en == 1'b0 && sdo == 1'b0, "R7 idle activity ignored",
          {duty_o, sdo_en, sdo}, {held, 2'b00});
      frame(16, 64'h0F0F, 16'h1234);
      chk(duty_o == 16'h0F0F, "R7 next frame unaffected", 64'(duty_o), 64'h0F0F);

      // R9 aborted short frame then a valid frame
      frame(5, 64'h1F, 16'h0000);
      chk(duty_o == 16'h0F0F, "R9 abort kept", 64'(duty_o), 64'h0F0F);
      frame(16, 64'h9AB2, 16'h7E7E);
      chk(duty_o == 16'h9AB2, "R9 count restarted", 64'(duty_o), 64'h9AB2);

      // random frames
      for (int k = 0; k < 24; k++) begin
         int n;
         logic [63:0] tx;
         case ($urandom % 4)
            0: n = 16;
            1: n = 32;
            2: n = 48;
            default: n = 1 + ($urandom % 47);
         endcase
         tx = {$urandom, $urandom};
         frame(n, tx, 16'($urandom));
      end

      // R8 reset after a commit
      frame(16, 64'hFFFF, 16'h0);
      rst = 1'b1; repeat (2) @(negedge clk);
      rst = 1'b0; repeat (2) @(negedge clk);
      chk(duty_o == 16'h0 && sdo_en == 1'b0, "R8 reset clears duties", {duty_o, sdo_en}, 64'd0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule